// File: doc/BRIEF.md
# Frame-Paced Serial Control Register File

This block gives a host microprocessor access to eight 8-bit control registers over one shared data line. The line does not shift on a fast bit clock. Each bit occupies one period of the 8 kHz frame sync, and the block samples it on the next frame-sync rising edge. The host opens a transfer by pulling the active-low enable low just after a frame-sync rising edge. It then presents a 3-bit register address, most significant bit first, followed by eight data bits, also most significant bit first.

Reads are indirect and take two transfers. The first transfer writes register 7 with the read-request bit (bit 3) set and the wanted register number in bits 2:0. When the enable next falls, the block clears the request bit and takes over the data line. During the eight frame slots that follow the three address slots, it shifts the selected register out, MSB first. It releases the line once the enable rises.

All register contents are available in parallel, and the fields of register 4 are also decoded onto dedicated outputs. Every input is resynchronised to the block clock, and all edges are detected on that clock.

Top module: `ctl_serial_regs`

## Requirements
- R1: After reset every register reads 0x00, except register 3, which reads 0x0F.
- R2: In a write transfer, the first 11 frame-sync rising edges after the enable falls capture A2, A1, A0, D7 down to D0 in that order. On the 11th edge, the data byte is written to the addressed register.
- R3: The data line is sampled only at frame-sync rising edges, so changes on it between those edges have no effect.
- R4: If the enable rises before 11 bits have been captured, the transfer is discarded and no register changes.
- R5: If register 7 bit 3 is 1 when the enable falls, that bit is cleared at once and register 7 bits 2:0 select the register to return. The other bits of register 7 are unchanged.
- R6: The output enable of the data line is high only during a read transfer, from shortly after the enable falls until just after it rises. It is low during write transfers.
- R7: In a read transfer, after the 3rd through the 10th frame-sync rising edges, the data line carries bits 7 down to 0 of the selected register. The address bits the host sends during that transfer are ignored. While the output is not enabled, the data output is 0.
- R8: A read transfer writes no register, apart from the clear described in R5.
- R9: The register 4 fields are decoded as follows: bit 6 is power-down request, bit 5 is echo-cancel enable, bits 3:2 select the master clock, and bits 1:0 select the codec format.
- R10: Frame-sync edges after the 11th, up to the enable rising, are ignored, so a long transfer causes exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, much faster than the frame sync |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_i | input | 1 | 8 kHz frame sync |
| sden_ni | input | 1 | Active-low transfer enable from the host |
| sdata_i | input | 1 | Serial data from the host |
| sdata_o | output | 1 | Serial data to the host during reads |
| sdata_oe_o | output | 1 | Drive enable for the shared data line |
| regs_o | output | 64 | All registers, register n in bits 8n+7:8n |
| pwr_down_o | output | 1 | Register 4 bit 6 |
| echo_en_o | output | 1 | Register 4 bit 5 |
| mclk_sel_o | output | 2 | Register 4 bits 3:2 |
| fmt_sel_o | output | 2 | Register 4 bits 1:0 |

## Verification
The hardest state to reach is a transfer whose direction was decided by a previous one. The bench must arm a read through register 7, and the following enable fall must then switch the block to output while address bits arrive that have to be ignored. Random sequences write register 7 with the request bit set at random points. Every following transfer is handled according to the bench's own model of that bit. Truncated and overlong transfers are mixed in, and the data line is glitched between frame edges throughout.

// File: rtl/ctl_serial_pkg.sv
package ctl_serial_pkg;
  localparam int DATA_W   = 8;
  localparam int NREG     = 8;
  localparam int ADDR_W   = 3;
  localparam int RD_REG   = 7;
  localparam int READ_BIT = 3;
  localparam int CFG_REG  = 4;
  localparam int PD_BIT   = 6;
  localparam int ECHO_BIT = 5;
  localparam int MCLK_LSB = 2;
  localparam int FMT_LSB  = 0;
  localparam logic [NREG*DATA_W-1:0] RST_VALS = 64'h0000_0000_0F00_0000;

  typedef enum logic [1:0] {XS_IDLE, XS_SHIFT, XS_DONE} xfer_state_t;
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[s] <= RST_VAL;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int DATA_W   = 8,
  parameter int NREG     = 8,
  parameter int ADDR_W   = 3,
  parameter int RD_REG   = 7,
  parameter int READ_BIT = 3,
  parameter logic [NREG*DATA_W-1:0] RST_VALS = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      waddr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic                   clr_rd_i,
  output logic [NREG*DATA_W-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= RST_VALS[g*DATA_W +: DATA_W];
      else if (we_i && waddr_i == ADDR_W'(g)) q <= wdata_i;
      else if (clr_rd_i && g == RD_REG) q[READ_BIT] <= 1'b0;
    end
    assign regs_o[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/ctl_xfer_fsm.sv
module ctl_xfer_fsm
  import ctl_serial_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NREG     = 8,
  parameter int ADDR_W   = 3,
  parameter int RD_REG   = 7,
  parameter int READ_BIT = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fs_i,
  input  logic                   sden_i,
  input  logic                   sdata_i,
  input  logic [NREG*DATA_W-1:0] regs_i,
  output logic                   we_o,
  output logic [ADDR_W-1:0]      waddr_o,
  output logic [DATA_W-1:0]      wdata_o,
  output logic                   clr_rd_o,
  output logic                   sdata_o,
  output logic                   oe_o
);
  localparam int NBITS = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(NBITS + 1);

  xfer_state_t        st;
  logic [CNT_W-1:0]   cnt;
  logic [NBITS-2:0]   sh;
  logic [NBITS-1:0]   word;
  logic [DATA_W-1:0]  rd_sh;
  logic               rd_mode, fs_q, sden_q;
  logic               fs_rise, sden_fall, sden_rise, rd_armed, in_win;
  logic [ADDR_W-1:0]  rd_sel;

  assign fs_rise   = fs_i & ~fs_q;
  assign sden_fall = ~sden_i & sden_q;
  assign sden_rise = sden_i & ~sden_q;
  assign rd_armed  = regs_i[RD_REG*DATA_W + READ_BIT];
  assign rd_sel    = regs_i[RD_REG*DATA_W +: ADDR_W];
  assign word      = {sh, sdata_i};
  assign clr_rd_o  = (st == XS_IDLE) && sden_fall && rd_armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= XS_IDLE;
      cnt     <= '0;
      sh      <= '0;
      rd_sh   <= '0;
      rd_mode <= 1'b0;
      fs_q    <= 1'b0;
      sden_q  <= 1'b1;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      fs_q   <= fs_i;
      sden_q <= sden_i;
      we_o   <= 1'b0;
      unique case (st)
        XS_IDLE: if (sden_fall) begin
          st      <= XS_SHIFT;
          cnt     <= '0;
          rd_mode <= rd_armed;
          rd_sh   <= regs_i[rd_sel*DATA_W +: DATA_W];
        end
        XS_SHIFT: begin
          if (sden_rise) st <= XS_IDLE;
          else if (fs_rise) begin
            sh  <= word[NBITS-2:0];
            cnt <= cnt + 1'b1;
            if (rd_mode && cnt >= CNT_W'(ADDR_W)) rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            if (cnt == CNT_W'(NBITS-1)) begin
              st      <= XS_DONE;
              we_o    <= ~rd_mode;
              waddr_o <= word[NBITS-1 -: ADDR_W];
              wdata_o <= word[DATA_W-1:0];
            end
          end
        end
        XS_DONE: if (sden_rise) st <= XS_IDLE;
        default: st <= XS_IDLE;
      endcase
    end
  end

  assign oe_o    = rd_mode && (st != XS_IDLE);
  assign in_win  = (cnt >= CNT_W'(ADDR_W)) && (cnt < CNT_W'(NBITS));
  assign sdata_o = oe_o && in_win && rd_sh[DATA_W-1];
endmodule

// File: rtl/ctl_serial_regs.sv
module ctl_serial_regs
  import ctl_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   fs_i,
  input  logic                   sden_ni,
  input  logic                   sdata_i,
  output logic                   sdata_o,
  output logic                   sdata_oe_o,
  output logic [NREG*DATA_W-1:0] regs_o,
  output logic                   pwr_down_o,
  output logic                   echo_en_o,
  output logic [1:0]             mclk_sel_o,
  output logic [1:0]             fmt_sel_o
);
  logic              fs_s, sden_s, sdata_s;
  logic              wr_en, clr_rd;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni,
    .d_i({fs_i, sden_ni, sdata_i}),
    .q_o({fs_s, sden_s, sdata_s})
  );

  ctl_xfer_fsm #(
    .DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W),
    .RD_REG(RD_REG), .READ_BIT(READ_BIT)
  ) u_fsm (
    .clk_i, .rst_ni,
    .fs_i(fs_s), .sden_i(sden_s), .sdata_i(sdata_s),
    .regs_i(regs_o),
    .we_o(wr_en), .waddr_o(wr_addr), .wdata_o(wr_data),
    .clr_rd_o(clr_rd),
    .sdata_o, .oe_o(sdata_oe_o)
  );

  ctl_reg_bank #(
    .DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W),
    .RD_REG(RD_REG), .READ_BIT(READ_BIT), .RST_VALS(RST_VALS)
  ) u_bank (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i(wr_data),
    .clr_rd_i(clr_rd),
    .regs_o
  );

  assign pwr_down_o = regs_o[CFG_REG*DATA_W + PD_BIT];
  assign echo_en_o  = regs_o[CFG_REG*DATA_W + ECHO_BIT];
  assign mclk_sel_o = regs_o[CFG_REG*DATA_W + MCLK_LSB +: 2];
  assign fmt_sel_o  = regs_o[CFG_REG*DATA_W + FMT_LSB +: 2];
endmodule

// File: rtl/ctl_serial_chk.sv
module ctl_serial_chk
  import ctl_serial_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   sden_lvl,
  input logic                   oe,
  input logic                   sdata,
  input logic                   we,
  input logic [NREG*DATA_W-1:0] regs
);
  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sden_lvl) |=> !oe);

  p_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe |-> !sdata);

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe) |-> !regs[RD_REG*DATA_W + READ_BIT]);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe && $past(oe)) |-> $stable(regs));

  p_nowrite_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> !oe);
endmodule

bind ctl_serial_regs ctl_serial_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sden_lvl(sden_s), .oe(sdata_oe_o),
  .sdata(sdata_o), .we(wr_en), .regs(regs_o)
);

// File: tb/sim_ctl_serial_regs.sv
module sim_ctl_serial_regs;
  localparam int CLK_PER = 10;
  localparam int FS_HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0, fs = 1'b0, sden_n = 1'b1, sdi = 1'b0;
  logic sdo, oe, pd, echo;
  logic [63:0] regs;
  logic [1:0] mclk, fmt;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m [8];

  always #(CLK_PER/2) clk = ~clk;

  ctl_serial_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .fs_i(fs), .sden_ni(sden_n), .sdata_i(sdi),
    .sdata_o(sdo), .sdata_oe_o(oe), .regs_o(regs), .pwr_down_o(pd),
    .echo_en_o(echo), .mclk_sel_o(mclk), .fmt_sel_o(fmt)
  );

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_regs(string tag);
    for (int i = 0; i < 8; i++) chk(regs[i*8 +: 8] == m[i], tag, regs[i*8 +: 8], m[i]);
  endtask

  task automatic check_dec(string tag);
    logic [5:0] e, a;
    e = {m[4][6], m[4][5], m[4][3:2], m[4][1:0]};
    a = {pd, echo, mclk, fmt};
    chk(a == e, tag, a, e);
  endtask

  task automatic pulse();
    @(negedge clk) fs = 1'b1;
    repeat (FS_HALF) @(negedge clk);
    fs = 1'b0;
    repeat (FS_HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [10:0] word, input int npl);
    bit rd;
    logic [7:0] exp_b, got;
    string tag;
    got = '0;
    exp_b = '0;
    @(negedge clk) sden_n = 1'b0;
    repeat (4) @(negedge clk);
    rd = m[7][3];
    if (rd) begin
      exp_b = m[m[7][2:0]];
      m[7][3] = 1'b0;
    end
    for (int i = 0; i < npl; i++) begin
      sdi = 1'($urandom);
      repeat (3) @(negedge clk);
      sdi = ~sdi;
      repeat (2) @(negedge clk);
      sdi = (i < 11) ? word[10-i] : 1'($urandom);
      repeat (2) @(negedge clk);
      pulse();
      if (rd) begin
        chk(oe == 1'b1, "R6 read drive", oe, 1);
        if (i+1 >= 3 && i+1 <= 10) got[10-(i+1)] = sdo;
      end else begin
        chk(oe == 1'b0, "R6 write no drive", oe, 0);
      end
    end
    if (rd && npl >= 11) chk(got == exp_b, "R7 read data", got, exp_b);
    @(negedge clk) sden_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(oe == 1'b0, "R6 release", oe, 0);
    if (!rd && npl >= 11) m[word[10:8]] = word[7:0];
    if (rd) tag = "R8 read keeps regs, R5";
    else if (npl < 11) tag = "R4 truncated";
    else if (npl > 11) tag = "R10 overlong";
    else tag = "R2 write, R3 glitch";
    check_regs(tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) m[i] = 8'h00;
    m[3] = 8'h0F;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check_regs("R1 reset");
    check_dec("R9 reset decode");
    chk(oe == 1'b0, "R6 reset", oe, 0);

    xfer({3'd4, 8'h6D}, 11);
    check_dec("R9 decode");
    chk({pd, echo, mclk, fmt} == 6'b11_11_01, "R9 fields", {pd, echo, mclk, fmt}, 6'b111101);
    xfer({3'd1, 8'hA5}, 7);
    xfer({3'd2, 8'h3C}, 13);
    xfer({3'd7, 8'h0B}, 11);
    xfer({3'b101, 8'hFF}, 11);
    chk(regs[63:56] == 8'h03, "R5 clear", regs[63:56], 8'h03);
    xfer({3'd7, 8'h0E}, 11);
    xfer({3'b000, 8'h00}, 11);

    for (int n = 0; n < 60; n++) begin
      logic [2:0] a;
      logic [7:0] d;
      int np;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd7 && ($urandom % 2) == 0) d[3] = 1'b0;
      if (($urandom % 6) == 0) begin
        a = 3'd7;
        d[3] = 1'b1;
      end
      case ($urandom % 10)
        0: np = 1 + int'($urandom % 10);
        1: np = 12 + int'($urandom % 3);
        default: np = 11;
      endcase
      xfer({a, d}, np);
      check_dec("R9 decode random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule